// File: doc/BRIEF.md
# Vector Register File Partition Allocator

This block splits the 256-entry vector register file of one SIMD unit into contiguous partitions, one per resident wavefront. A launch request states how many registers each wavefront of its shader needs. The block looks for a free wavefront slot and for the lowest run of free registers long enough to hold the request. If it finds both, it records the run's start in that slot and answers with a grant carrying the slot number and base. If it cannot find both, it answers with a reject.

While a wavefront runs, it names its registers with local indices starting at zero. The block translates a slot and a local index into a physical register address, and it flags an index that lies beyond the slot's allocation. When a wavefront retires, a release of its slot returns both the slot and its register range to the free pool.

Occupancy follows from register demand. With a uniform count N, at most min(floor(256/N), 10) wavefronts are resident. Registers left over at the top can still hold a wavefront of another shader with a smaller count.

Top module: `vrf_part_alloc`

## Requirements
- R1: After reset no slot is resident: grant and reject are low, and every translation reports an error with physical address 0.
- R2: A request sampled at a clock edge produces exactly one single-cycle pulse, either grant or reject, in the cycle after that edge. With no request, neither pulse is raised.
- R3: A grant uses the lowest-numbered slot that is not resident. Slots are numbered 0 to 9.
- R4: A grant places the range at the lowest base from which N consecutive registers are all free (first fit, scanning upward from register 0). Base plus N never exceeds 256.
- R5: From an empty state, repeated requests with the same N are granted exactly min(floor(256/N), 10) times, the k-th at slot k and base k·N, and the next request is rejected.
- R6: A request is rejected when all 10 slots are resident or no free run of N registers exists, and no resident state changes.
- R7: A request with N = 0 or N > 256 is rejected and changes no state. The count field is 9 bits wide.
- R8: For a resident slot and a local index below its N, translation gives base + index with the error flag low.
- R9: For a local index of N or more, or for a slot that is not resident, translation raises the error flag and gives physical address 0.
- R10: A release of a resident slot frees the slot and its range at that clock edge. A request at the same edge still sees them occupied, and a request at any later edge may reuse them.
- R11: Registers left free by one count can be granted to a request with a different count when the run fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch request strobe |
| req_count | input | 9 | Registers per wavefront (N) |
| grant | output | 1 | One-cycle grant pulse |
| reject | output | 1 | One-cycle reject pulse |
| grant_slot | output | 4 | Slot granted, valid with grant |
| grant_base | output | 8 | Range base granted, valid with grant |
| rel_valid | input | 1 | Release strobe |
| rel_slot | input | 4 | Slot to release |
| xl_slot | input | 4 | Slot to translate |
| xl_index | input | 8 | Wavefront-local register index |
| xl_phys | output | 8 | Physical register address |
| xl_err | output | 1 | Index out of range or slot not resident |

## Verification
Every count from 1 to 256 is tried on an empty allocator and filled until the first reject. This separates the counts where the slot cap of 10 limits occupancy from those where the 256 registers do, and it checks each base and each translation at local index 0, at N−1 and at N. Counts of 0, 257 and 511 each probe the illegal-count path. A mixed sequence of four requests of 60, one of 16 and one of 17 shows leftover reuse and a reject for lack of space. A release landing on the same edge as a request is then told apart from a release that comes one cycle earlier. A final step releases a middle range and refills it with a smaller count, which shows first fit into a hole.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    localparam int VRF_DEPTH_DEF = 256;
    localparam int VRF_WAVES_DEF = 10;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_GRANT  = 2'd1,
        RSP_REJECT = 2'd2
    } rsp_e;
endpackage

// File: rtl/vrf_occ_map.sv
module vrf_occ_map #(
    parameter int NUM_REGS  = 256,
    parameter int MAX_SLOTS = 10,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int CNT_W    = $clog2(NUM_REGS + 1)
) (
    input  logic [MAX_SLOTS-1:0]            slot_act,
    input  logic [MAX_SLOTS-1:0][REG_W-1:0] slot_base,
    input  logic [MAX_SLOTS-1:0][CNT_W-1:0] slot_cnt,
    output logic [NUM_REGS-1:0]             occ
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_comb begin
            occ[r] = 1'b0;
            for (int s = 0; s < MAX_SLOTS; s++) begin
                if (slot_act[s] && (r >= int'(slot_base[s]))
                    && (r < int'(slot_base[s]) + int'(slot_cnt[s]))) begin
                    occ[r] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vrf_gap_finder.sv
module vrf_gap_finder #(
    parameter int NUM_REGS = 256,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = $clog2(NUM_REGS + 1)
) (
    input  logic [NUM_REGS-1:0] occ,
    input  logic [CNT_W-1:0]    need,
    output logic                found,
    output logic [REG_W-1:0]    base
);
    always_comb begin
        int run;
        int pos;
        run   = 0;
        pos   = 0;
        found = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (occ[i]) begin
                run = 0;
            end else begin
                run = run + 1;
            end
            if (!found && (need != '0) && (run == int'(need))) begin
                found = 1'b1;
                pos   = i + 1 - int'(need);
            end
        end
        base = REG_W'(pos);
    end
endmodule

// File: rtl/vrf_slot_pick.sv
module vrf_slot_pick #(
    parameter int MAX_SLOTS = 10,
    localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic [MAX_SLOTS-1:0] slot_act,
    output logic                 found,
    output logic [SLOT_W-1:0]    slot
);
    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int s = 0; s < MAX_SLOTS; s++) begin
            if (!found && !slot_act[s]) begin
                found = 1'b1;
                slot  = SLOT_W'(s);
            end
        end
    end
endmodule

// File: rtl/vrf_part_alloc.sv
module vrf_part_alloc
    import vrf_pkg::*;
#(
    parameter int NUM_REGS  = VRF_DEPTH_DEF,
    parameter int MAX_SLOTS = VRF_WAVES_DEF,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int CNT_W    = $clog2(NUM_REGS + 1),
    localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CNT_W-1:0]  req_count,
    output logic              grant,
    output logic              reject,
    output logic [SLOT_W-1:0] grant_slot,
    output logic [REG_W-1:0]  grant_base,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot,
    input  logic [SLOT_W-1:0] xl_slot,
    input  logic [REG_W-1:0]  xl_index,
    output logic [REG_W-1:0]  xl_phys,
    output logic              xl_err
);
    typedef struct packed {
        logic [MAX_SLOTS-1:0]            act;
        logic [MAX_SLOTS-1:0][REG_W-1:0] base;
        logic [MAX_SLOTS-1:0][CNT_W-1:0] cnt;
        rsp_e                            rsp;
        logic [SLOT_W-1:0]               g_slot;
        logic [REG_W-1:0]                g_base;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_REGS-1:0] occ;
    logic                gap_ok, slot_ok, cnt_ok;
    logic [REG_W-1:0]    gap_base;
    logic [SLOT_W-1:0]   free_slot;

    vrf_occ_map #(.NUM_REGS(NUM_REGS), .MAX_SLOTS(MAX_SLOTS)) u_occ (
        .slot_act (st_q.act),
        .slot_base(st_q.base),
        .slot_cnt (st_q.cnt),
        .occ      (occ)
    );

    vrf_gap_finder #(.NUM_REGS(NUM_REGS)) u_gap (
        .occ  (occ),
        .need (req_count),
        .found(gap_ok),
        .base (gap_base)
    );

    vrf_slot_pick #(.MAX_SLOTS(MAX_SLOTS)) u_pick (
        .slot_act(st_q.act),
        .found   (slot_ok),
        .slot    (free_slot)
    );

    assign cnt_ok = (req_count != '0) && (int'(req_count) <= NUM_REGS);

    always_comb begin
        st_d     = st_q;
        st_d.rsp = RSP_NONE;
        if (req_valid) begin
            if (cnt_ok && slot_ok && gap_ok) begin
                st_d.rsp             = RSP_GRANT;
                st_d.g_slot          = free_slot;
                st_d.g_base          = gap_base;
                st_d.act[free_slot]  = 1'b1;
                st_d.base[free_slot] = gap_base;
                st_d.cnt[free_slot]  = req_count;
            end else begin
                st_d.rsp = RSP_REJECT;
            end
        end
        if (rel_valid && (int'(rel_slot) < MAX_SLOTS) && st_q.act[rel_slot]) begin
            st_d.act[rel_slot] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant      = (st_q.rsp == RSP_GRANT);
    assign reject     = (st_q.rsp == RSP_REJECT);
    assign grant_slot = st_q.g_slot;
    assign grant_base = st_q.g_base;

    logic xl_live, xl_in;
    assign xl_live = (int'(xl_slot) < MAX_SLOTS) && st_q.act[xl_slot];
    assign xl_in   = xl_live && ({1'b0, xl_index} < st_q.cnt[xl_slot]);
    assign xl_err  = !xl_in;
    assign xl_phys = xl_in ? (st_q.base[xl_slot] + xl_index) : '0;

    p_one_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject));

    p_resp_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant || reject));

    p_no_req_no_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(grant || reject));

    p_fit_in_file_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!grant || (int'(grant_base) + int'($past(req_count)) <= NUM_REGS)));

    p_bad_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cnt_ok) |=> reject);

    p_release_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && (int'(rel_slot) < MAX_SLOTS)) |=> !st_q.act[$past(rel_slot)]);

    p_err_phys_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xl_err |-> (xl_phys == '0));
endmodule

// File: tb/vrf_part_alloc_tb.sv
module vrf_part_alloc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [8:0] req_count = '0;
    logic       grant, reject;
    logic [3:0] grant_slot;
    logic [7:0] grant_base;
    logic       rel_valid = 1'b0;
    logic [3:0] rel_slot = '0;
    logic [3:0] xl_slot = '0;
    logic [7:0] xl_index = '0;
    logic [7:0] xl_phys;
    logic       xl_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vrf_part_alloc u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_count(req_count),
        .grant(grant), .reject(reject),
        .grant_slot(grant_slot), .grant_base(grant_base),
        .rel_valid(rel_valid), .rel_slot(rel_slot),
        .xl_slot(xl_slot), .xl_index(xl_index),
        .xl_phys(xl_phys), .xl_err(xl_err)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive a request for one edge and sample the response after it.
    task automatic do_req(input int n, output logic g, output logic r,
                          output int slot, output int base);
        @(negedge clk);
        req_valid = 1'b1;
        req_count = 9'(n);
        @(negedge clk);
        req_valid = 1'b0;
        g    = grant;
        r    = reject;
        slot = int'(grant_slot);
        base = int'(grant_base);
    endtask

    task automatic do_rel(input int s);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_slot  = 4'(s);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic xlate(input int s, input int idx, output int phys, output logic err);
        xl_slot  = 4'(s);
        xl_index = 8'(idx);
        #1;
        phys = int'(xl_phys);
        err  = xl_err;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic g, r, e;
        int s, b, p;

        do_reset();
        // R1: empty after reset
        @(negedge clk);
        chk(!grant && !reject, "R1 no pulse after reset", int'(grant | reject), 0);
        for (int k = 0; k < 10; k++) begin
            xlate(k, 0, p, e);
            chk(e && p == 0, "R1 slot not resident after reset", p, 0);
        end
        // R2: quiet without request
        @(negedge clk);
        chk(!grant && !reject, "R2 no pulse without request", int'(grant | reject), 0);

        // R5/R3/R4/R8/R9/R6: sweep every legal count
        for (int n = 1; n <= 256; n++) begin
            int lim;
            lim = 256 / n;
            if (lim > 10) lim = 10;
            do_reset();
            for (int k = 0; k < lim; k++) begin
                do_req(n, g, r, s, b);
                chk(g && !r, "R2 R5 grant expected", int'(g), 1);
                chk(s == k, "R3 slot order", s, k);
                chk(b == k * n, "R4 R5 uniform base", b, k * n);
            end
            do_req(n, g, r, s, b);
            chk(r && !g, "R5 R6 reject after full occupancy", int'(r), 1);
            for (int k = 0; k < lim; k++) begin
                xlate(k, 0, p, e);
                chk(!e && p == k * n, "R8 translate index 0", p, k * n);
                xlate(k, n - 1, p, e);
                chk(!e && p == k * n + n - 1, "R8 translate last index", p, k * n + n - 1);
                if (n <= 255) begin
                    xlate(k, n, p, e);
                    chk(e && p == 0, "R9 index beyond count", p, 0);
                end
            end
            if (lim < 10) begin
                xlate(lim, 0, p, e);
                chk(e && p == 0, "R9 inactive slot", p, 0);
            end
        end

        // R7: illegal counts, state untouched
        do_reset();
        do_req(0, g, r, s, b);
        chk(r && !g, "R7 count zero rejected", int'(r), 1);
        do_req(257, g, r, s, b);
        chk(r && !g, "R7 count 257 rejected", int'(r), 1);
        do_req(511, g, r, s, b);
        chk(r && !g, "R7 count 511 rejected", int'(r), 1);
        do_req(256, g, r, s, b);
        chk(g && s == 0 && b == 0, "R7 state unchanged after illegal counts", b, 0);

        // R11: leftover reuse with a different count
        do_reset();
        for (int k = 0; k < 4; k++) do_req(60, g, r, s, b);
        do_req(16, g, r, s, b);
        chk(g && s == 4 && b == 240, "R11 leftover granted", b, 240);
        do_req(17, g, r, s, b);
        chk(r, "R6 no gap rejected", int'(r), 1);
        xlate(4, 15, p, e);
        chk(!e && p == 255, "R8 R11 leftover translate", p, 255);

        // R10: release on same edge as request is not yet visible
        @(negedge clk);
        rel_valid = 1'b1; rel_slot = 4'd0;
        req_valid = 1'b1; req_count = 9'd60;
        @(negedge clk);
        rel_valid = 1'b0; req_valid = 1'b0;
        chk(reject && !grant, "R10 same-edge release not visible", int'(reject), 1);
        xlate(0, 0, p, e);
        chk(e, "R10 released slot not resident", int'(e), 1);
        do_req(60, g, r, s, b);
        chk(g && s == 0 && b == 0, "R10 reuse next cycle", b, 0);

        // R4: first fit into a middle hole
        do_rel(1);
        do_req(50, g, r, s, b);
        chk(g && s == 1 && b == 60, "R4 hole refill base", b, 60);
        do_req(10, g, r, s, b);
        chk(g && s == 5 && b == 110, "R4 R3 second hole fill", b, 110);
        do_req(1, g, r, s, b);
        chk(r, "R6 no space left", int'(r), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule